// File: doc/BRIEF.md
# Window and Timeout Watchdog Core

This block checks that a host processor is still alive. The host programs it through a small write-only register port and services it by writing the all-ones byte to a service address. A one-millisecond tick input is the time base. In window operation the period is split into two equal halves. A service in the first (closed) half counts as an error. A service in the second (open) half is correct. In timeout operation a service is correct at any time. In both modes, letting the whole period pass without a service is an error.

Errors raise an interrupt level at once. They also move an error counter toward a programmable threshold. When the threshold is reached, the block fires an event. The event takes one of three actions: an interrupt only, a timed supply-off request, or a low pulse on a reset-request line. A limp-home output goes high on any error and is released by one of three programmable rules.

Register map (address: contents). Address 0 is timing: bit 0 selects the mode (0 window, 1 timeout), bits 2:1 hold the prescaler and bits 5:3 hold the multiplier. Address 1 is event setup: bits 1:0 hold the threshold, bits 3:2 the action and bits 5:4 the limp release rule. Address 2 is the service address. Address 3 is the command address: bit 0 releases limp-home and bit 1 clears the interrupt.

Top module: `wdog_core`

## Requirements
- R1: In window mode, a service less than period/2 ticks after the timer started or restarted is an error. A later service is correct. Either one restarts the count.
- R2: In timeout mode any service before expiry is correct and restarts the full period. In both modes, reaching period ticks without a service is an error and restarts the count.
- R3: The period in ms is computed from the multiplier m and prescaler p, with s = p+1. The values are: m=0 gives 4s, m=1 gives 32s, m=2 gives 128s, m=3 gives 256/384/512/768, m=4 gives 512s, m=5 gives 2048s, and m=6 gives 10240 (p=0) or 20240 (p=1).
- R4: A service is a write of 0xFF to address 2. Any other data written there is ignored. While stopped, the first service starts the timer without being counted as correct.
- R5: The error counter is 4 after reset. It rises by 1 on each error and falls by 1, never below 0, on each correct service.
- R6: On an error, an event fires when the incremented count reaches the limit. The limit is 1 for threshold 00 or 11, 5 for threshold 01, and 9 for threshold 10.
- R7: `irq_o` goes high on every error, whatever the threshold. It stays high until a write of 1 to command bit 1; an error in the same cycle wins.
- R8: The event action depends on the action field. 00 (or 11) only sets the interrupt. 01 holds `supply_off_o` high for 100 ticks. 10 drives `rst_req_n_o` low for 4 ticks.
- R9: `limp_o` goes high on any error. It is released by the rule field: 00 on the third correct service since the last error, 01 on the first, 10 (or 11) on a write of 1 to command bit 0. That command bit is ignored under rules 00 and 01.
- R10: Multiplier 6 with prescaler 1x, and multiplier 7, are reserved. They hold the timer stopped, ignore services and never raise an error.
- R11: After an event, the error counter returns to 4 and the timer stops until a new first service.
- R12: After reset, the configuration is window mode with a 4 ms period, `irq_o`, `supply_off_o` and `limp_o` are low, and `rst_req_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms_i | input | 1 | One-cycle strobe per millisecond |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| irq_o | output | 1 | Interrupt request level, high on error |
| supply_off_o | output | 1 | Supply-off request |
| rst_req_n_o | output | 1 | Reset request, active low pulse |
| limp_o | output | 1 | Limp-home level |

## Verification
Some rules are checked by assertions on every cycle. These are: every error sets the interrupt on the next edge; every service or expiry restarts the count; reserved periods stay silent; a correct service lowers the counter by one; an event reloads the counter and stops the timer; and a supply-off request starts only from an event. Other behaviour can only be shown by the bench's scenarios. This covers the exact threshold at which events fire (fifth versus ninth error), the length of the supply-off and reset pulses, and the three limp-home release rules, including a software release being ignored. It also covers the computed period at more than one setting.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int TIME_W = 15;

  typedef enum logic [1:0] {
    ACT_IRQ    = 2'b00,
    ACT_SUPPLY = 2'b01,
    ACT_RSTREQ = 2'b10,
    ACT_RSV    = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    REL_THIRD = 2'b00,
    REL_FIRST = 2'b01,
    REL_SW    = 2'b10,
    REL_RSV   = 2'b11
  } rel_e;

  typedef struct packed {
    logic [2:0] mul;
    logic [1:0] pre;
    logic       mode;
  } tcfg_t;

  typedef struct packed {
    rel_e       rule;
    act_e       act;
    logic [1:0] thr;
  } ecfg_t;

  // Returns {valid, period_in_ticks}
  function automatic logic [TIME_W:0] period_ms(input logic [2:0] mul, input logic [1:0] pre);
    logic [TIME_W-1:0] step;
    logic [TIME_W-1:0] val;
    logic              ok;
    step = TIME_W'(pre) + 1'b1;
    ok   = 1'b1;
    val  = '0;
    case (mul)
      3'd0: val = TIME_W'(4) * step;
      3'd1: val = TIME_W'(32) * step;
      3'd2: val = TIME_W'(128) * step;
      3'd3: begin
        case (pre)
          2'd0:    val = TIME_W'(256);
          2'd1:    val = TIME_W'(384);
          2'd2:    val = TIME_W'(512);
          default: val = TIME_W'(768);
        endcase
      end
      3'd4: val = TIME_W'(512) * step;
      3'd5: val = TIME_W'(2048) * step;
      3'd6: begin
        case (pre)
          2'd0:    val = TIME_W'(10240);
          2'd1:    val = TIME_W'(20240);
          default: ok = 1'b0;
        endcase
      end
      default: ok = 1'b0;
    endcase
    return {ok, val};
  endfunction
endpackage

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int TIME_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              svc,
  input  logic              mode,
  input  logic [TIME_W-1:0] period,
  input  logic              rsvd,
  input  logic              stop,
  output logic              good,
  output logic              bad,
  output logic              expired,
  output logic              running,
  output logic [TIME_W-1:0] cnt
);
  logic [TIME_W-1:0] half;
  logic              live;

  assign half    = period >> 1;
  assign live    = running && !rsvd;
  assign good    = live && svc && (mode || (cnt >= half));
  assign bad     = live && svc && !mode && (cnt < half);
  assign expired = live && !svc && tick && (cnt >= period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (stop || rsvd) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      if (svc) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end else if (svc || expired) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_errcnt.sv
`timescale 1ns/1ps
module wdog_errcnt #(
  parameter int ERR_W    = 4,
  parameter int ERR_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err,
  input  logic             good,
  input  logic [1:0]       thr,
  output logic             fire,
  output logic [ERR_W-1:0] count
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;
  localparam logic [ERR_W-1:0] CNT_RST = ERR_W'(ERR_INIT);

  logic [ERR_W-1:0] inc;
  logic [ERR_W-1:0] limit;

  always_comb begin
    case (thr)
      2'b01:   limit = ERR_W'(5);
      2'b10:   limit = ERR_W'(9);
      default: limit = ERR_W'(1);
    endcase
  end

  assign inc  = (count == CNT_MAX) ? count : count + 1'b1;
  assign fire = err && (inc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= CNT_RST;
    else if (fire)            count <= CNT_RST;
    else if (err)             count <= inc;
    else if (good && count != '0) count <= count - 1'b1;
  end
endmodule

// File: rtl/wdog_react.sv
`timescale 1ns/1ps
module wdog_react
  import wdog_pkg::*;
#(
  parameter int SUPPLY_MS = 100,
  parameter int PULSE_MS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic err,
  input  logic good,
  input  logic fire,
  input  act_e act,
  input  rel_e rule,
  input  logic irq_clr,
  input  logic limp_rel,
  output logic irq_o,
  output logic supply_off_o,
  output logic rst_req_n_o,
  output logic limp_o
);
  localparam int SUP_W = $clog2(SUPPLY_MS + 1);
  localparam int PUL_W = $clog2(PULSE_MS + 1);

  logic [SUP_W-1:0] sup_cnt;
  logic [PUL_W-1:0] pul_cnt;
  logic [1:0]       good_seen;
  logic             rel_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_o <= 1'b0;
    else if (err)     irq_o <= 1'b1;
    else if (irq_clr) irq_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                sup_cnt <= '0;
    else if (fire && act == ACT_SUPPLY)        sup_cnt <= SUP_W'(SUPPLY_MS);
    else if (tick && sup_cnt != '0)            sup_cnt <= sup_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                pul_cnt <= '0;
    else if (fire && act == ACT_RSTREQ)        pul_cnt <= PUL_W'(PULSE_MS);
    else if (tick && pul_cnt != '0)            pul_cnt <= pul_cnt - 1'b1;
  end

  assign supply_off_o = (sup_cnt != '0);
  assign rst_req_n_o  = (pul_cnt == '0);

  always_comb begin
    case (rule)
      REL_THIRD: rel_now = good && (good_seen == 2'd2);
      REL_FIRST: rel_now = good;
      default:   rel_now = limp_rel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limp_o    <= 1'b0;
      good_seen <= '0;
    end else if (err) begin
      limp_o    <= 1'b1;
      good_seen <= '0;
    end else if (limp_o) begin
      if (rel_now) begin
        limp_o    <= 1'b0;
        good_seen <= '0;
      end else if (good && good_seen != 2'd3) begin
        good_seen <= good_seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core
  import wdog_pkg::*;
#(
  parameter int ERR_W     = 4,
  parameter int ERR_INIT  = 4,
  parameter int SUPPLY_MS = 100,
  parameter int PULSE_MS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms_i,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic       irq_o,
  output logic       supply_off_o,
  output logic       rst_req_n_o,
  output logic       limp_o
);
  localparam logic [1:0] A_TIME = 2'd0;
  localparam logic [1:0] A_EVT  = 2'd1;
  localparam logic [1:0] A_SVC  = 2'd2;
  localparam logic [1:0] A_CMD  = 2'd3;

  tcfg_t             tcfg;
  ecfg_t             ecfg;
  logic [TIME_W:0]   per_w;
  logic [TIME_W-1:0] period;
  logic              p_rsvd;
  logic              svc;
  logic              t_good, t_bad, t_exp, t_run;
  logic [TIME_W-1:0] t_cnt;
  logic              e_fire;
  logic [ERR_W-1:0]  e_count;
  logic              any_err;
  logic              cmd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcfg <= '0;
      ecfg <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_addr_i == A_TIME) tcfg <= tcfg_t'(cfg_wdata_i[5:0]);
      if (cfg_addr_i == A_EVT)  ecfg <= ecfg_t'(cfg_wdata_i[5:0]);
    end
  end

  assign per_w   = period_ms(tcfg.mul, tcfg.pre);
  assign period  = per_w[TIME_W-1:0];
  assign p_rsvd  = !per_w[TIME_W];
  assign svc     = cfg_wr_i && (cfg_addr_i == A_SVC) && (cfg_wdata_i == 8'hFF);
  assign cmd_wr  = cfg_wr_i && (cfg_addr_i == A_CMD);
  assign any_err = t_bad || t_exp;

  wdog_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms_i), .svc(svc),
    .mode(tcfg.mode), .period(period), .rsvd(p_rsvd), .stop(e_fire),
    .good(t_good), .bad(t_bad), .expired(t_exp), .running(t_run), .cnt(t_cnt)
  );

  wdog_errcnt #(.ERR_W(ERR_W), .ERR_INIT(ERR_INIT)) u_err (
    .clk(clk), .rst_n(rst_n), .err(any_err), .good(t_good), .thr(ecfg.thr),
    .fire(e_fire), .count(e_count)
  );

  wdog_react #(.SUPPLY_MS(SUPPLY_MS), .PULSE_MS(PULSE_MS)) u_react (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms_i), .err(any_err), .good(t_good),
    .fire(e_fire), .act(ecfg.act), .rule(ecfg.rule),
    .irq_clr(cmd_wr && cfg_wdata_i[1]), .limp_rel(cmd_wr && cfg_wdata_i[0]),
    .irq_o(irq_o), .supply_off_o(supply_off_o), .rst_req_n_o(rst_req_n_o), .limp_o(limp_o)
  );
endmodule

// File: rtl/wdog_core_chk.sv
`timescale 1ns/1ps
module wdog_core_chk #(
  parameter int TIME_W   = 15,
  parameter int ERR_W    = 4,
  parameter int ERR_INIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              good,
  input logic              bad,
  input logic              expired,
  input logic              running,
  input logic              rsvd,
  input logic              fire,
  input logic [TIME_W-1:0] cnt,
  input logic [ERR_W-1:0]  errs,
  input logic              irq,
  input logic              supply
);
  assert_irq_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bad || expired) |=> irq);

  assert_restart_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (good || bad || expired) |=> (cnt == '0));

  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd |-> !(good || bad || expired));

  assert_event_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (errs == ERR_W'(ERR_INIT)) && !running);

  assert_good_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    good |=> (errs == (($past(errs) == '0) ? '0 : $past(errs) - 1'b1)));

  assert_supply_from_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply) |-> $past(fire));
endmodule

bind wdog_core wdog_core_chk #(.TIME_W(wdog_pkg::TIME_W), .ERR_W(ERR_W), .ERR_INIT(ERR_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .good(t_good), .bad(t_bad), .expired(t_exp),
  .running(t_run), .rsvd(p_rsvd), .fire(e_fire), .cnt(t_cnt), .errs(e_count),
  .irq(irq_o), .supply(supply_off_o)
);

// File: tb/test_wdog_core.sv
`timescale 1ns/1ps
module test_wdog_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       irq, sup, rstn, limp;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wdog_core i_wdog_core (
    .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .cfg_wr_i(wr), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .irq_o(irq), .supply_off_o(sup), .rst_req_n_o(rstn), .limp_o(limp)
  );

  // {kind(1=ticks), addr, arg, expected {irq,sup,rstn,limp}, requirement number}
  localparam logic [26:0] VEC [0:19] = '{
    {1'b0, 2'd1, 16'h0019, 4'b0010, 4'd6},  // R6 thr 5th, action reset pulse, rule first
    {1'b0, 2'd2, 16'h00FF, 4'b0010, 4'd4},  // R4 first service starts timer
    {1'b0, 2'd2, 16'h00FF, 4'b1001, 4'd1},  // R1 closed-half service -> error, count 5 fires
    {1'b0, 2'd3, 16'h0002, 4'b0001, 4'd7},  // R7 interrupt clear
    {1'b1, 2'd0, 16'd4,    4'b0011, 4'd11}, // R11 timer stopped, R8 pulse 4 ticks
    {1'b0, 2'd2, 16'h00FF, 4'b0011, 4'd4},  // R4 restart
    {1'b1, 2'd0, 16'd2,    4'b0011, 4'd1},  // R1
    {1'b0, 2'd2, 16'h00FF, 4'b0010, 4'd9},  // R9 open-half good releases (rule first)
    {1'b1, 2'd0, 16'd4,    4'b1011, 4'd5},  // R5 expiry, count 3->4, no event
    {1'b0, 2'd3, 16'h0002, 4'b0011, 4'd7},  // R7
    {1'b0, 2'd0, 16'h0001, 4'b0011, 4'd2},  // R2 timeout mode
    {1'b1, 2'd0, 16'd3,    4'b0011, 4'd2},  // R2
    {1'b0, 2'd2, 16'h00FF, 4'b0010, 4'd2},  // R2 early service is correct
    {1'b1, 2'd0, 16'd3,    4'b0010, 4'd2},  // R2 full period restarted
    {1'b1, 2'd0, 16'd1,    4'b1011, 4'd2},  // R2 expiry
    {1'b0, 2'd1, 16'h0024, 4'b1011, 4'd8},  // R8 thr every, supply-off, rule software
    {1'b1, 2'd0, 16'd4,    4'b1111, 4'd8},  // R8 supply-off on event
    {1'b1, 2'd0, 16'd99,   4'b1111, 4'd8},  // R8
    {1'b1, 2'd0, 16'd1,    4'b1011, 4'd8},  // R8 after 100 ticks
    {1'b0, 2'd3, 16'h0001, 4'b1010, 4'd9}   // R9 software release
  };

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {irq, sup, rstn, limp};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {irq,sup,rstn,limp} got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset state", 4'b0010);

    for (int v = 0; v < 20; v++) begin
      if (VEC[v][26]) ticks(int'(VEC[v][23:8]));
      else            wr_reg(VEC[v][25:24], VEC[v][15:8]);
      check($sformatf("R%0d vector %0d", VEC[v][3:0], v), VEC[v][7:4]);
    end

    // R12: reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset after activity", 4'b0010);

    // R6: ninth-error threshold with supply action, R9 third-service rule
    wr_reg(2'd1, 8'h06);
    wr_reg(2'd2, 8'hFF);
    for (int k = 1; k <= 4; k++) begin
      ticks(4);
      check($sformatf("R6 no event after error %0d", k), 4'b1011);
    end
    ticks(4);
    check("R6 event on ninth count", 4'b1111);
    wr_reg(2'd3, 8'h01);
    check("R9 software release ignored under rule 00", 4'b1111);
    ticks(100);
    check("R8 supply-off ended", 4'b1011);
    wr_reg(2'd2, 8'hFF);
    ticks(2); wr_reg(2'd2, 8'hFF);
    check("R9 limp held after first good", 4'b1011);
    ticks(2); wr_reg(2'd2, 8'hFF);
    check("R9 limp held after second good", 4'b1011);
    ticks(2); wr_reg(2'd2, 8'hFF);
    check("R9 limp released on third good", 4'b1010);

    // R10: reserved period stays silent
    wr_reg(2'd3, 8'h02);
    wr_reg(2'd0, 8'h34);
    ticks(20);
    wr_reg(2'd2, 8'hFF);
    ticks(20);
    check("R10 reserved period no error", 4'b0010);

    // R4: non-0xFF data does not start the timer
    wr_reg(2'd0, 8'h09);
    wr_reg(2'd2, 8'hFE);
    ticks(40);
    check("R4 wrong service data ignored", 4'b0010);

    // R3: 32 ms timeout period
    wr_reg(2'd2, 8'hFF);
    ticks(31);
    check("R3 no expiry at 31 ticks", 4'b0010);
    ticks(1);
    check("R3 expiry at 32 ticks", 4'b1011);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule